// File: doc/BRIEF.md
# SCSI Controller Command and Interrupt Register Block

This block is the host-facing byte register window of a SCSI bus controller. A host bus reaches sixteen byte registers on a four-byte stride. The block decodes command bytes written by software. It keeps the status, interrupt-reason and sequence-step registers and drives a registered interrupt line. Commands that need the external selection or transfer engines produce a one-cycle service pulse, which carries the command code and its DMA flag.

The engines report back through simple done inputs, and those inputs set the status picture. The block does not hold the FIFO data. It runs the data-port handshake: a byte counter, read and write pointers for an external buffer, and write and read strobes.

Reading the interrupt-reason register has side effects. It clears the status register except for the terminal-count bit, drops the interrupt line and clears a DMA-side interrupt flag. The reason byte itself is kept.

Top module: `scsi_ctl_regs`

## Requirements
- R1: After reset, every register reads 0x00 except index 14, which reads the identification code 0x04. The `irq`, `dma_irq_flag` and `fifo_count` outputs are 0.
- R2: Registers 0, 1, 3, 8 and 12 to 15 read back the last byte written to them. Register 11 keeps only the bits under mask 0x15. Writes to registers 4, 5, 6, 7, 9 and 10 leave their read values unchanged.
- R3: The register index is `host_addr[5:2]`. Address bits [1:0] are ignored.
- R4: The flush command (code 0x01) sets the reason register to 0x08 and the step register (index 6) to 0. It does not change the interrupt line.
- R5: The bus-reset command (code 0x03) sets the reason register to 0x80. It raises `irq` and `dma_irq_flag` only when bit 6 of register 8 is 0.
- R6: A host read of the reason register (index 5) leaves only bit 4 (terminal count) of the status register (index 4). It deasserts `irq` and `dma_irq_flag` on the next cycle.
- R7: Command codes 0x10, 0x42 and 0x43 give a one-cycle `svc_pulse` in the cycle after the write. The pulse comes with `svc_cmd` = bits [6:0] of the command byte and `svc_dma` = bit 7.
- R8: Selection done with a target found sets status 0x91, reason 0x18 and step 4. Selection done with no target sets status 0x80, reason 0x20 and step 0. Both raise `irq`.
- R9: Transfer done sets status to 0x90 ORed with the 3-bit bus phase (0 data-out, 1 data-in, 3 status, 6 message-in, 7 message-out). It also sets reason 0x10 and step 0, and raises `irq`.
- R10: FIFO data port (index 2):
  - A write while the count is below 16 pulses `fifo_wr_stb`, increments the count and the write pointer. A write while the count is 16 is ignored.
  - A read while the count is nonzero returns the external byte, pulses `fifo_rd_stb`, decrements the count and advances the read pointer.
  - Both pointers return to 0 when the count reaches 0. A read while empty returns 0x00.
  - Register 7 reads the count.
- R11: The chip-reset command (code 0x02) returns all registers, the FIFO count, the pointers and `irq` to the R1 state.
- R12: The command-complete command (0x11) sets status 0x93, reason 0x18 and step 4. The message-accepted command (0x12) sets status 0x93, reason 0x20 and step 0. Both raise `irq`.
- R13: The no-op command (0x00) and the set-attention command (0x1A) change no register and give no `svc_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 6 | Host byte address; bits [5:2] select the register |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (enables read side effects) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the addressed register |
| svc_pulse | output | 1 | One-cycle request to the selection/transfer engines |
| svc_cmd | output | 7 | Command code carried with the request |
| svc_dma | output | 1 | DMA flag carried with the request |
| sel_done | input | 1 | Selection engine finished |
| sel_found | input | 1 | Selection found a target (valid with sel_done) |
| xfer_done | input | 1 | Transfer engine finished |
| xfer_phase | input | 3 | Bus phase reported with xfer_done |
| fifo_wr_stb | output | 1 | Write one byte into the external FIFO buffer |
| fifo_wr_byte | output | 8 | Byte to write |
| fifo_rd_stb | output | 1 | One byte consumed from the external FIFO buffer |
| fifo_rd_byte | input | 8 | External buffer byte at fifo_rptr |
| fifo_wptr | output | 4 | External buffer write pointer |
| fifo_rptr | output | 4 | External buffer read pointer |
| fifo_count | output | 5 | Bytes held in the FIFO |
| irq | output | 1 | Registered interrupt level |
| dma_irq_flag | output | 1 | DMA-side copy of the interrupt flag |

## Verification
The status logic is driven with each completion source in turn:
- selection done with and without a target,
- transfer done with two different phases,
- the internally completed commands,
- bus reset with the mask bit clear and set.

These runs separate the status, reason and step values that each source must produce. After each source the reason register is read, which checks that terminal count survives the clear while the interrupt line drops. The FIFO port is exercised three ways:
- a short fill and drain, which shows the pointers returning to zero,
- a read while empty,
- a fill past sixteen bytes, which shows the excess write being dropped.

Register writes go to writable, masked and read-only indices, which tells a correct write mask apart from an over-permissive one.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;

    localparam int unsigned REG_IDX_W = 4;
    localparam int unsigned NUM_REGS  = 16;

    // register indices whose position matters to software
    localparam logic [3:0] RI_FIFO   = 4'd2;
    localparam logic [3:0] RI_CMD    = 4'd3;
    localparam logic [3:0] RI_STAT   = 4'd4;
    localparam logic [3:0] RI_REASON = 4'd5;
    localparam logic [3:0] RI_STEP   = 4'd6;
    localparam logic [3:0] RI_COUNT  = 4'd7;
    localparam logic [3:0] RI_CFG    = 4'd8;
    localparam logic [3:0] RI_CFG_M  = 4'd11;
    localparam logic [3:0] RI_ID     = 4'd14;

    // indices that hold host-written bytes: 0,1,3,8,11,12..15
    localparam logic [15:0] REG_WRITABLE = 16'hF90B;
    localparam logic [7:0]  CFG_M_MASK   = 8'h15;
    localparam int unsigned BUS_RST_MASK_BIT = 6;

    // command codes (bits [6:0] of the command byte)
    localparam logic [6:0] OP_NOP      = 7'h00;
    localparam logic [6:0] OP_FLUSH    = 7'h01;
    localparam logic [6:0] OP_CHIP_RST = 7'h02;
    localparam logic [6:0] OP_BUS_RST  = 7'h03;
    localparam logic [6:0] OP_XFER     = 7'h10;
    localparam logic [6:0] OP_CMD_CPLT = 7'h11;
    localparam logic [6:0] OP_MSG_ACC  = 7'h12;
    localparam logic [6:0] OP_SET_ATN  = 7'h1A;
    localparam logic [6:0] OP_SEL      = 7'h42;
    localparam logic [6:0] OP_SEL_STOP = 7'h43;

    // status bits and phases
    localparam logic [7:0] ST_INT = 8'h80;
    localparam logic [7:0] ST_TC  = 8'h10;

    typedef enum logic [2:0] {
        PH_DATA_OUT = 3'd0,
        PH_DATA_IN  = 3'd1,
        PH_COMMAND  = 3'd2,
        PH_STATUS   = 3'd3,
        PH_MSG_IN   = 3'd6,
        PH_MSG_OUT  = 3'd7
    } bus_phase_e;

    // reason bits
    localparam logic [7:0] RS_FUNC_DONE = 8'h08;
    localparam logic [7:0] RS_BUS_SVC   = 8'h10;
    localparam logic [7:0] RS_DISCON    = 8'h20;
    localparam logic [7:0] RS_BUS_RST   = 8'h80;

    localparam logic [7:0] STEP_IDLE     = 8'h00;
    localparam logic [7:0] STEP_CMD_DONE = 8'h04;

    typedef struct packed {
        logic       valid;
        logic       dma;
        logic [6:0] code;
        logic       flush;
        logic       chip_rst;
        logic       bus_rst;
        logic       xfer;
        logic       cmd_cplt;
        logic       msg_acc;
        logic       select;
        logic       hits_status;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic en, input logic [7:0] b);
        cmd_dec_t d;
        d       = '0;
        d.valid = en;
        d.dma   = b[7];
        d.code  = b[6:0];
        if (en) begin
            case (b[6:0])
                OP_FLUSH:    d.flush    = 1'b1;
                OP_CHIP_RST: d.chip_rst = 1'b1;
                OP_BUS_RST:  d.bus_rst  = 1'b1;
                OP_XFER:     d.xfer     = 1'b1;
                OP_CMD_CPLT: d.cmd_cplt = 1'b1;
                OP_MSG_ACC:  d.msg_acc  = 1'b1;
                OP_SEL,
                OP_SEL_STOP: d.select   = 1'b1;
                default:     ;
            endcase
        end
        d.hits_status = d.flush | d.chip_rst | d.bus_rst | d.cmd_cplt | d.msg_acc;
        return d;
    endfunction

    function automatic logic [7:0] reg_reset_value(input int unsigned i, input logic [7:0] id_code);
        return (i == int'(RI_ID)) ? id_code : 8'h00;
    endfunction

    function automatic logic [7:0] reg_write_mask(input int unsigned i);
        return (i == int'(RI_CFG_M)) ? CFG_M_MASK : 8'hFF;
    endfunction

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
    import scsi_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_cmd,
    input  logic [7:0] wdata,
    output cmd_dec_t   dec
);

    always_comb dec = decode_cmd(wr_cmd, wdata);

    // at most one action class per command byte
    a_r7_single_action: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dec.flush, dec.chip_rst, dec.bus_rst, dec.xfer,
                  dec.cmd_cplt, dec.msg_acc, dec.select}));

    // R13: no-op and set-attention decode to no action
    a_r13_inert_ops: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && (wdata[6:0] == OP_NOP || wdata[6:0] == OP_SET_ATN))
        |-> !(dec.hits_status || dec.xfer || dec.select));

endmodule

// File: rtl/scsi_fifo_port.sv
module scsi_fifo_port #(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          push,
    input  logic          pop,
    input  logic [7:0]    push_byte,
    output logic          wr_stb,
    output logic [7:0]    wr_byte,
    output logic          rd_stb,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [AW:0]   count
);

    localparam int unsigned CNT_W = AW + 1;
    localparam logic [AW:0] DEPTH = CNT_W'(1 << AW);

    logic [AW:0]   cnt_q, cnt_nx;
    logic [AW-1:0] wptr_q, rptr_q;
    logic          do_push, do_pop;

    assign do_push = push && (cnt_q != DEPTH);
    assign do_pop  = pop  && (cnt_q != '0);
    assign cnt_nx  = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cnt_q  <= '0;
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            cnt_q <= cnt_nx;
            if (cnt_nx == '0) begin
                wptr_q <= '0;
                rptr_q <= '0;
            end else begin
                if (do_push) wptr_q <= wptr_q + 1'b1;
                if (do_pop)  rptr_q <= rptr_q + 1'b1;
            end
        end
    end

    assign wr_stb  = do_push;
    assign wr_byte = push_byte;
    assign rd_stb  = do_pop;
    assign wptr    = wptr_q;
    assign rptr    = rptr_q;
    assign count   = cnt_q;

    a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= DEPTH);

    a_r10_empty_ptrs: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) |-> (wptr_q == '0 && rptr_q == '0));

    a_r10_full_push_drop: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (push && !pop && cnt_q == DEPTH) |=> (cnt_q == DEPTH));

endmodule

// File: rtl/scsi_int_status.sv
module scsi_int_status
    import scsi_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_dec_t   dec,
    input  logic       bus_rst_mask,
    input  logic       sel_done,
    input  logic       sel_found,
    input  logic       xfer_done,
    input  logic [2:0] xfer_phase,
    input  logic       rd_reason,
    output logic [7:0] status,
    output logic [7:0] reason,
    output logic [7:0] step,
    output logic       irq,
    output logic       dma_flag
);

    logic [7:0] status_q, reason_q, step_q;
    logic       irq_q, flag_q;

    always_ff @(posedge clk) begin
        if (rst || dec.chip_rst) begin
            status_q <= '0;
            reason_q <= '0;
            step_q   <= '0;
            irq_q    <= 1'b0;
            flag_q   <= 1'b0;
        end else if (dec.bus_rst) begin
            reason_q <= RS_BUS_RST;
            if (!bus_rst_mask) begin
                irq_q  <= 1'b1;
                flag_q <= 1'b1;
            end
        end else if (dec.flush) begin
            reason_q <= RS_FUNC_DONE;
            step_q   <= STEP_IDLE;
        end else if (dec.cmd_cplt || dec.msg_acc) begin
            status_q <= ST_INT | ST_TC | 8'(PH_STATUS);
            reason_q <= dec.cmd_cplt ? (RS_BUS_SVC | RS_FUNC_DONE) : RS_DISCON;
            step_q   <= dec.cmd_cplt ? STEP_CMD_DONE : STEP_IDLE;
            irq_q    <= 1'b1;
            flag_q   <= 1'b1;
        end else if (sel_done) begin
            if (sel_found) begin
                status_q <= ST_INT | ST_TC | 8'(PH_DATA_IN);
                reason_q <= RS_BUS_SVC | RS_FUNC_DONE;
                step_q   <= STEP_CMD_DONE;
            end else begin
                status_q <= ST_INT;
                reason_q <= RS_DISCON;
                step_q   <= STEP_IDLE;
            end
            irq_q  <= 1'b1;
            flag_q <= 1'b1;
        end else if (xfer_done) begin
            status_q <= ST_INT | ST_TC | {5'b0, xfer_phase};
            reason_q <= RS_BUS_SVC;
            step_q   <= STEP_IDLE;
            irq_q    <= 1'b1;
            flag_q   <= 1'b1;
        end else if (rd_reason) begin
            status_q <= status_q & ST_TC;
            irq_q    <= 1'b0;
            flag_q   <= 1'b0;
        end
    end

    assign status   = status_q;
    assign reason   = reason_q;
    assign step     = step_q;
    assign irq      = irq_q;
    assign dma_flag = flag_q;

    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_reason && !dec.hits_status && !sel_done && !xfer_done)
        |=> (status_q == ($past(status_q) & ST_TC)) && !irq_q && !flag_q);

    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (dec.bus_rst && bus_rst_mask && !irq_q) |=> !irq_q && reason_q == RS_BUS_RST);

    a_r5_unmasked_raise: assert property (@(posedge clk) disable iff (rst)
        (dec.bus_rst && !bus_rst_mask) |=> irq_q && flag_q);

    a_r8_no_target: assert property (@(posedge clk) disable iff (rst)
        (sel_done && !sel_found && !dec.hits_status)
        |=> status_q == ST_INT && reason_q == RS_DISCON && step_q == STEP_IDLE && irq_q);

    a_r4_flush_keeps_irq: assert property (@(posedge clk) disable iff (rst)
        dec.flush |=> irq_q == $past(irq_q) && reason_q == RS_FUNC_DONE);

endmodule

// File: rtl/scsi_ctl_regs.sv
module scsi_ctl_regs
    import scsi_ctl_pkg::*;
#(
    parameter int unsigned FIFO_AW = 4,
    parameter logic [7:0]  ID_CODE = 8'h04
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [5:0]         host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    output logic               svc_pulse,
    output logic [6:0]         svc_cmd,
    output logic               svc_dma,
    input  logic               sel_done,
    input  logic               sel_found,
    input  logic               xfer_done,
    input  logic [2:0]         xfer_phase,
    output logic               fifo_wr_stb,
    output logic [7:0]         fifo_wr_byte,
    output logic               fifo_rd_stb,
    input  logic [7:0]         fifo_rd_byte,
    output logic [FIFO_AW-1:0] fifo_wptr,
    output logic [FIFO_AW-1:0] fifo_rptr,
    output logic [FIFO_AW:0]   fifo_count,
    output logic               irq,
    output logic               dma_irq_flag
);

    localparam int unsigned CNT_W = FIFO_AW + 1;

    logic [REG_IDX_W-1:0] idx;
    logic                 wr_cmd, push, pop, rd_reason, soft_rst;
    cmd_dec_t             dec;
    logic [7:0]           store_q [NUM_REGS];
    logic [7:0]           status, reason, step;
    logic [CNT_W-1:0]     count;

    assign idx       = host_addr[5:2];
    assign wr_cmd    = host_wr && (idx == RI_CMD);
    assign push      = host_wr && (idx == RI_FIFO);
    assign pop       = host_rd && (idx == RI_FIFO);
    assign rd_reason = host_rd && (idx == RI_REASON);
    assign soft_rst  = dec.chip_rst;

    scsi_cmd_decode u_decode (
        .clk   (clk),
        .rst   (rst),
        .wr_cmd(wr_cmd),
        .wdata (host_wdata),
        .dec   (dec)
    );

    scsi_fifo_port #(.AW(FIFO_AW)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .push     (push),
        .pop      (pop),
        .push_byte(host_wdata),
        .wr_stb   (fifo_wr_stb),
        .wr_byte  (fifo_wr_byte),
        .rd_stb   (fifo_rd_stb),
        .wptr     (fifo_wptr),
        .rptr     (fifo_rptr),
        .count    (count)
    );

    scsi_int_status u_status (
        .clk         (clk),
        .rst         (rst),
        .dec         (dec),
        .bus_rst_mask(store_q[RI_CFG][BUS_RST_MASK_BIT]),
        .sel_done    (sel_done),
        .sel_found   (sel_found),
        .xfer_done   (xfer_done),
        .xfer_phase  (xfer_phase),
        .rd_reason   (rd_reason),
        .status      (status),
        .reason      (reason),
        .step        (step),
        .irq         (irq),
        .dma_flag    (dma_irq_flag)
    );

    // host-written byte registers; read-only indices stay at their reset value
    always_ff @(posedge clk) begin
        for (int unsigned i = 0; i < NUM_REGS; i++) begin
            if (rst || soft_rst) begin
                store_q[i] <= reg_reset_value(i, ID_CODE);
            end else if (REG_WRITABLE[i] && host_wr && (idx == REG_IDX_W'(i))) begin
                store_q[i] <= host_wdata & reg_write_mask(i);
            end
        end
    end

    // engine request pulse
    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            svc_pulse <= 1'b0;
            svc_cmd   <= '0;
            svc_dma   <= 1'b0;
        end else begin
            svc_pulse <= dec.xfer || dec.select;
            if (dec.xfer || dec.select) begin
                svc_cmd <= dec.code;
                svc_dma <= dec.dma;
            end
        end
    end

    always_comb begin
        case (idx)
            RI_FIFO:   host_rdata = (count != '0) ? fifo_rd_byte : 8'h00;
            RI_STAT:   host_rdata = status;
            RI_REASON: host_rdata = reason;
            RI_STEP:   host_rdata = step;
            RI_COUNT:  host_rdata = 8'(count);
            default:   host_rdata = store_q[idx];
        endcase
    end

    assign fifo_count = count;

    a_r7_svc_from_cmd: assert property (@(posedge clk) disable iff (rst)
        svc_pulse |-> $past(wr_cmd));

    a_r11_chip_reset: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst) |-> (!irq && count == '0 && !svc_pulse));

    a_r2_ro_status_write: assert property (@(posedge clk) disable iff (rst)
        (host_wr && idx == RI_STAT && !host_rd && !sel_done && !xfer_done && !soft_rst)
        |=> $stable(status));

endmodule

// File: tb/sim_scsi_ctl_regs.sv
`timescale 1ns/1ps
module sim_scsi_ctl_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       svc_pulse, svc_dma;
    logic [6:0] svc_cmd;
    logic       sel_done = 1'b0, sel_found = 1'b0, xfer_done = 1'b0;
    logic [2:0] xfer_phase = '0;
    logic       fifo_wr_stb, fifo_rd_stb;
    logic [7:0] fifo_wr_byte, fifo_rd_byte;
    logic [3:0] fifo_wptr, fifo_rptr;
    logic [4:0] fifo_count;
    logic       irq, dma_irq_flag;

    logic [7:0] ext_mem [16];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    always @(posedge clk) if (fifo_wr_stb) ext_mem[fifo_wptr] <= fifo_wr_byte;
    assign fifo_rd_byte = ext_mem[fifo_rptr];

    scsi_ctl_regs u0 (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .svc_pulse(svc_pulse), .svc_cmd(svc_cmd), .svc_dma(svc_dma),
        .sel_done(sel_done), .sel_found(sel_found), .xfer_done(xfer_done),
        .xfer_phase(xfer_phase), .fifo_wr_stb(fifo_wr_stb), .fifo_wr_byte(fifo_wr_byte),
        .fifo_rd_stb(fifo_rd_stb), .fifo_rd_byte(fifo_rd_byte), .fifo_wptr(fifo_wptr),
        .fifo_rptr(fifo_rptr), .fifo_count(fifo_count), .irq(irq), .dma_irq_flag(dma_irq_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] addr, input logic [7:0] d);
        @(negedge clk);
        host_addr = addr; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] addr, output logic [7:0] d);
        @(negedge clk);
        host_addr = addr; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic logic [5:0] ra(input int i);
        return 6'(i << 2);
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        rd(ra(4), v);  chk("R1 status", v, 8'h00);
        rd(ra(6), v);  chk("R1 step", v, 8'h00);
        rd(ra(14), v); chk("R1 id code", v, 8'h04);
        rd(ra(5), v);  chk("R1 reason", v, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 count", fifo_count, 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(ra(0), 8'h5A);  rd(ra(0), v);  chk("R2 reg0", v, 8'h5A);
        wr(ra(12), 8'hC3); rd(ra(12), v); chk("R2 reg12", v, 8'hC3);
        wr(ra(11), 8'hFF); rd(ra(11), v); chk("R2 reg11 mask", v, 8'h15);
        wr(ra(4), 8'hFF);  rd(ra(4), v);  chk("R2 reg4 read-only", v, 8'h00);
        wr(ra(9), 8'h77);  rd(ra(9), v);  chk("R2 reg9 read-only", v, 8'h00);
        wr(ra(7), 8'h33);  rd(ra(7), v);  chk("R2 reg7 read-only", v, 8'h00);
        wr(ra(14), 8'h21); rd(ra(14), v); chk("R2 reg14", v, 8'h21);
        // R3: low address bits ignored
        wr(6'h07, 8'h3C);  rd(6'h04, v);  chk("R3 stride", v, 8'h3C);
    endtask

    task automatic t_flush_inert();
        logic [7:0] v;
        wr(ra(3), 8'h01);
        chk("R4 irq unchanged", irq, 0);
        rd(ra(6), v); chk("R4 step", v, 8'h00);
        rd(ra(5), v); chk("R4 reason", v, 8'h08);
        wr(ra(3), 8'h00);
        chk("R13 nop no svc", svc_pulse, 0);
        wr(ra(3), 8'h1A);
        chk("R13 atn no svc", svc_pulse, 0);
        rd(ra(5), v); chk("R13 reason kept", v, 8'h08);
        chk("R13 irq", irq, 0);
    endtask

    task automatic t_bus_reset();
        logic [7:0] v;
        wr(ra(8), 8'h00);
        wr(ra(3), 8'h03);
        chk("R5 irq unmasked", irq, 1);
        chk("R5 dma flag", dma_irq_flag, 1);
        rd(ra(5), v); chk("R5 reason", v, 8'h80);
        chk("R6 irq dropped", irq, 0);
        chk("R6 dma flag dropped", dma_irq_flag, 0);
        wr(ra(8), 8'h40);
        wr(ra(3), 8'h03);
        chk("R5 irq masked", irq, 0);
        rd(ra(5), v); chk("R5 reason masked", v, 8'h80);
        wr(ra(8), 8'h00);
    endtask

    task automatic t_select();
        logic [7:0] v;
        wr(ra(3), 8'hC2);
        chk("R7 pulse", svc_pulse, 1);
        chk("R7 cmd", svc_cmd, 7'h42);
        chk("R7 dma", svc_dma, 1);
        @(negedge clk);
        chk("R7 one cycle", svc_pulse, 0);
        sel_done = 1'b1; sel_found = 1'b1;
        @(negedge clk);
        sel_done = 1'b0;
        chk("R8 irq found", irq, 1);
        rd(ra(4), v); chk("R8 status found", v, 8'h91);
        rd(ra(6), v); chk("R8 step found", v, 8'h04);
        rd(ra(5), v); chk("R8 reason found", v, 8'h18);
        rd(ra(4), v); chk("R6 keeps tc", v, 8'h10);
        chk("R6 irq low", irq, 0);
        wr(ra(3), 8'h43);
        chk("R7 cmd stop", svc_cmd, 7'h43);
        chk("R7 no dma", svc_dma, 0);
        sel_done = 1'b1; sel_found = 1'b0;
        @(negedge clk);
        sel_done = 1'b0;
        chk("R8 irq none", irq, 1);
        rd(ra(4), v); chk("R8 status none", v, 8'h80);
        rd(ra(6), v); chk("R8 step none", v, 8'h00);
        rd(ra(5), v); chk("R8 reason none", v, 8'h20);
        rd(ra(4), v); chk("R6 cleared", v, 8'h00);
    endtask

    task automatic t_xfer();
        logic [7:0] v;
        wr(ra(3), 8'h90);
        chk("R7 xfer pulse", svc_pulse, 1);
        chk("R7 xfer code", svc_cmd, 7'h10);
        xfer_done = 1'b1; xfer_phase = 3'd1;
        @(negedge clk);
        xfer_done = 1'b0;
        rd(ra(4), v); chk("R9 status data-in", v, 8'h91);
        rd(ra(5), v); chk("R9 reason", v, 8'h10);
        xfer_done = 1'b1; xfer_phase = 3'd3;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R9 irq", irq, 1);
        rd(ra(4), v); chk("R9 status phase", v, 8'h93);
        rd(ra(6), v); chk("R9 step", v, 8'h00);
        rd(ra(5), v);
    endtask

    task automatic t_complete();
        logic [7:0] v;
        wr(ra(3), 8'h11);
        chk("R12 ccs irq", irq, 1);
        rd(ra(4), v); chk("R12 ccs status", v, 8'h93);
        rd(ra(6), v); chk("R12 ccs step", v, 8'h04);
        rd(ra(5), v); chk("R12 ccs reason", v, 8'h18);
        wr(ra(3), 8'h12);
        chk("R12 msg irq", irq, 1);
        rd(ra(6), v); chk("R12 msg step", v, 8'h00);
        rd(ra(5), v); chk("R12 msg reason", v, 8'h20);
    endtask

    task automatic t_fifo();
        logic [7:0] v;
        wr(ra(2), 8'hA1); wr(ra(2), 8'hB2); wr(ra(2), 8'hC3);
        chk("R10 count 3", fifo_count, 3);
        chk("R10 wptr 3", fifo_wptr, 3);
        rd(ra(7), v); chk("R10 count reg", v, 8'h03);
        rd(ra(2), v); chk("R10 byte0", v, 8'hA1);
        chk("R10 rptr 1", fifo_rptr, 1);
        rd(ra(2), v); chk("R10 byte1", v, 8'hB2);
        rd(ra(2), v); chk("R10 byte2", v, 8'hC3);
        chk("R10 empty count", fifo_count, 0);
        chk("R10 ptrs reset", {fifo_wptr, fifo_rptr}, 0);
        rd(ra(2), v); chk("R10 empty read", v, 8'h00);
        chk("R10 empty stays", fifo_count, 0);
        for (int i = 0; i < 16; i++) wr(ra(2), 8'(i * 7 + 1));
        chk("R10 full", fifo_count, 16);
        wr(ra(2), 8'hEE);
        chk("R10 overflow dropped", fifo_count, 16);
        for (int i = 0; i < 16; i++) begin
            rd(ra(2), v); chk("R10 drain", v, 8'(i * 7 + 1));
        end
        chk("R10 drained", fifo_count, 0);
    endtask

    task automatic t_chip_reset();
        logic [7:0] v;
        wr(ra(0), 8'h11); wr(ra(13), 8'h99);
        wr(ra(2), 8'h55); wr(ra(2), 8'h66);
        wr(ra(3), 8'h03);
        chk("R11 pre irq", irq, 1);
        wr(ra(3), 8'h02);
        chk("R11 irq", irq, 0);
        chk("R11 count", fifo_count, 0);
        chk("R11 dma flag", dma_irq_flag, 0);
        for (int i = 0; i < 16; i++) begin
            rd(ra(i), v);
            chk("R11 register value", v, (i == 14) ? 8'h04 : 8'h00);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_flush_inert();
        t_bus_reset();
        t_select();
        t_xfer();
        t_complete();
        t_fifo();
        t_chip_reset();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule